// File: doc/BRIEF.md
# Sampling clock tuning control

This block keeps the control and status state of the receive-sampling tuning procedure. Software sets an execute bit to launch a tuning run. A tuning engine outside this block answers with a completion strobe and a pass/fail flag. The block turns that answer into the clock-select value that the receive path uses to choose between the tuned sampling clock and the fixed one.

Software can also clear the select bit to reset the tuning circuit, or clear the execute bit to abort a run that is in progress. Start, abort and reset are issued as single-cycle pulses. A select update that is due while a response or read block is arriving is held back until the receive-busy input drops.

Top module: `tune_ctrl`

## Requirements
- R1: After reset every output is 0.
- R2: A write of 1 to the execute bit while it is 0 sets it (`rdExec`=1) and raises `tuneStart` for exactly one cycle, both in the cycle after the write. A write of 1 while the bit is already 1 has no effect and raises no pulse.
- R3: While the execute bit is 1, `engDone` clears it in the next cycle. With `engPass`=1 the select becomes 1 (tuned clock). With `engPass`=0 the select becomes 0 (fixed clock).
- R4: A write of 0 to the execute bit while it is 1 clears it and raises `tuneAbort` for one cycle. A completion that arrives in the same cycle as the abort, or after it, is ignored.
- R5: A software write of 1 to the select bit changes nothing.
- R6: A software write of 0 to the select bit raises `tuneReset` for one cycle and sets the select to 0.
- R7: Setting the execute bit sets the select to 0.
- R8: `sampleSel` does not change in any cycle that follows a cycle with `rxBusy`=1. A pending update is held and takes effect at the first clock edge at which `rxBusy` is 0. When several updates are pending, the newest one wins.
- R9: `rdSel` equals `sampleSel` when the execute bit is 0 and reads 0 while it is 1.
- R10: `tuneStart` and `tuneAbort` never stay high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrExecEn | input | 1 | Write strobe for the execute bit |
| wrExecVal | input | 1 | Value written to the execute bit |
| wrSelEn | input | 1 | Write strobe for the select bit |
| wrSelVal | input | 1 | Value written to the select bit |
| engDone | input | 1 | Tuning engine reports completion |
| engPass | input | 1 | Tuning result, 1 = success (valid with engDone) |
| rxBusy | input | 1 | A response or read data block is being received |
| tuneStart | output | 1 | One-cycle start pulse to the engine |
| tuneAbort | output | 1 | One-cycle abort pulse to the engine |
| tuneReset | output | 1 | One-cycle tuning-circuit reset pulse |
| sampleSel | output | 1 | Clock select for the receive path, 1 = tuned, 0 = fixed |
| rdExec | output | 1 | Read-back of the execute bit |
| rdSel | output | 1 | Read-back of the select bit |

## Verification
The hardest case to reach is a select update that is deferred while the receive-busy input is high. This matters most when the deferred update is overwritten by a second event before busy drops, or when a run starts while the select is still frozen at 1, so that the readback and the receive-path select disagree. The stimulus holds `rxBusy` high across a complete start/complete sequence and across a select clear. It then releases busy and checks that the newest value lands on the next edge. It also launches a run while busy holds the select at 1.

// File: rtl/tune_ctrl_pkg.sv
package tune_ctrl_pkg;
  typedef struct packed {
    logic loadZero;   // start or software clear forces select to 0
    logic loadResult; // engine completion delivers a result
    logic resultVal;  // pass flag accompanying loadResult
  } selStrobe_t;
endpackage

// File: rtl/tune_ctrl_fsm.sv
module tune_ctrl_fsm
  import tune_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrExecEn,
  input  logic       wrExecVal,
  input  logic       wrSelEn,
  input  logic       wrSelVal,
  input  logic       engDone,
  input  logic       engPass,
  output logic       execBit,
  output logic       startPulse,
  output logic       abortPulse,
  output logic       resetPulse,
  output selStrobe_t strobe
);
  logic evStart, evAbort, evDone, evClear;

  always_comb begin
    evStart = wrExecEn && wrExecVal && !execBit;
    evAbort = wrExecEn && !wrExecVal && execBit;
    evDone  = engDone && execBit && !evAbort;
    evClear = wrSelEn && !wrSelVal;
    strobe.loadZero   = evStart || evClear;
    strobe.loadResult = evDone;
    strobe.resultVal  = engPass;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      execBit    <= 1'b0;
      startPulse <= 1'b0;
      abortPulse <= 1'b0;
      resetPulse <= 1'b0;
    end else begin
      startPulse <= evStart;
      abortPulse <= evAbort;
      resetPulse <= evClear;
      if (evStart)
        execBit <= 1'b1;
      else if (evAbort || evDone)
        execBit <= 1'b0;
    end
  end
endmodule

// File: rtl/tune_ctrl_sel.sv
module tune_ctrl_sel
  import tune_ctrl_pkg::*;
#(
  parameter logic SEL_INIT = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxBusy,
  input  selStrobe_t strobe,
  output logic       selReg
);
  logic pendValid, pendVal;
  logic updValid, updVal, nextValid, nextVal;

  always_comb begin
    updValid  = strobe.loadZero || strobe.loadResult;
    updVal    = strobe.loadZero ? 1'b0 : strobe.resultVal;
    nextValid = updValid || pendValid;
    nextVal   = updValid ? updVal : pendVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg    <= SEL_INIT;
      pendValid <= 1'b0;
      pendVal   <= 1'b0;
    end else if (nextValid && !rxBusy) begin
      selReg    <= nextVal;
      pendValid <= 1'b0;
    end else if (nextValid) begin
      pendValid <= 1'b1;
      pendVal   <= nextVal;
    end
  end
endmodule

// File: rtl/tune_ctrl.sv
module tune_ctrl
  import tune_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic wrExecEn,
  input  logic wrExecVal,
  input  logic wrSelEn,
  input  logic wrSelVal,
  input  logic engDone,
  input  logic engPass,
  input  logic rxBusy,
  output logic tuneStart,
  output logic tuneAbort,
  output logic tuneReset,
  output logic sampleSel,
  output logic rdExec,
  output logic rdSel
);
  selStrobe_t strobe;
  logic       execBit;
  logic       selReg;

  tune_ctrl_fsm u_fsm (
    .clk(clk), .rstN(rstN),
    .wrExecEn(wrExecEn), .wrExecVal(wrExecVal),
    .wrSelEn(wrSelEn), .wrSelVal(wrSelVal),
    .engDone(engDone), .engPass(engPass),
    .execBit(execBit), .startPulse(tuneStart),
    .abortPulse(tuneAbort), .resetPulse(tuneReset),
    .strobe(strobe)
  );

  tune_ctrl_sel #(.SEL_INIT(1'b0)) u_sel (
    .clk(clk), .rstN(rstN), .rxBusy(rxBusy),
    .strobe(strobe), .selReg(selReg)
  );

  assign sampleSel = selReg;
  assign rdExec    = execBit;
  assign rdSel     = execBit ? 1'b0 : selReg;
endmodule

// File: rtl/tune_ctrl_chk.sv
module tune_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic rxBusy,
  input logic tuneStart,
  input logic tuneAbort,
  input logic tuneReset,
  input logic sampleSel,
  input logic rdExec,
  input logic rdSel
);
  assert_start_sets_exec_R2: assert property (@(posedge clk) disable iff (!rstN)
    tuneStart |-> rdExec);
  assert_abort_clears_exec_R4: assert property (@(posedge clk) disable iff (!rstN)
    tuneAbort |-> !rdExec);
  assert_clear_zeroes_sel_R6: assert property (@(posedge clk) disable iff (!rstN)
    tuneReset |-> (!sampleSel || $past(rxBusy)));
  assert_start_zeroes_sel_R7: assert property (@(posedge clk) disable iff (!rstN)
    tuneStart |-> (!sampleSel || $past(rxBusy)));
  assert_hold_while_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxBusy |=> $stable(sampleSel));
  assert_readback_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdExec |-> !rdSel);
  assert_start_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    tuneStart |=> !tuneStart);
  assert_abort_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    tuneAbort |=> !tuneAbort);
endmodule

bind tune_ctrl tune_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .rxBusy(rxBusy),
  .tuneStart(tuneStart), .tuneAbort(tuneAbort), .tuneReset(tuneReset),
  .sampleSel(sampleSel), .rdExec(rdExec), .rdSel(rdSel)
);

// File: tb/tune_ctrl_tb.sv
module tune_ctrl_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrExecEn = 0, wrExecVal = 0, wrSelEn = 0, wrSelVal = 0;
  logic engDone = 0, engPass = 0, rxBusy = 0;
  logic tuneStart, tuneAbort, tuneReset, sampleSel, rdExec, rdSel;

  int nChecks = 0;
  int nFails = 0;

  // behavioural reference state
  int mExec = 0, mSel = 0, mStart = 0, mAbort = 0, mRst = 0;
  int pendQ[$];

  always #(CLK_P/2) clk = ~clk;

  tune_ctrl u_dut (
    .clk(clk), .rstN(rstN),
    .wrExecEn(wrExecEn), .wrExecVal(wrExecVal),
    .wrSelEn(wrSelEn), .wrSelVal(wrSelVal),
    .engDone(engDone), .engPass(engPass), .rxBusy(rxBusy),
    .tuneStart(tuneStart), .tuneAbort(tuneAbort), .tuneReset(tuneReset),
    .sampleSel(sampleSel), .rdExec(rdExec), .rdSel(rdSel)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model: one step per rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mExec = 0; mSel = 0; mStart = 0; mAbort = 0; mRst = 0;
      pendQ.delete();
    end else begin
      int wasExec;
      wasExec = mExec;
      mStart = (wrExecEn && wrExecVal && wasExec == 0) ? 1 : 0;
      mAbort = (wrExecEn && !wrExecVal && wasExec == 1) ? 1 : 0;
      mRst   = (wrSelEn && !wrSelVal) ? 1 : 0;
      if (mStart == 1 || mRst == 1) pendQ.push_back(0);
      else if (engDone && wasExec == 1 && mAbort == 0) pendQ.push_back(engPass ? 1 : 0);
      if (mStart == 1) mExec = 1;
      else if (mAbort == 1) mExec = 0;
      else if (engDone && wasExec == 1) mExec = 0;
      if (!rxBusy && pendQ.size() > 0) begin
        mSel = pendQ[pendQ.size()-1];
        pendQ.delete();
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R2", "tuneStart", tuneStart, mStart);
      check("R4", "tuneAbort", tuneAbort, mAbort);
      check("R6", "tuneReset", tuneReset, mRst);
      check("R3", "sampleSel", sampleSel, mSel);
      check("R2", "rdExec", rdExec, mExec);
      check("R9", "rdSel", rdSel, (mExec != 0) ? 0 : mSel);
    end
  end

  task automatic step(input logic xe, input logic xv, input logic se, input logic sv,
                      input logic dn, input logic ps);
    wrExecEn = xe; wrExecVal = xv; wrSelEn = se; wrSelVal = sv;
    engDone = dn; engPass = ps;
    @(posedge clk); #1;
    wrExecEn = 0; wrExecVal = 0; wrSelEn = 0; wrSelVal = 0; engDone = 0; engPass = 0;
  endtask

  task automatic idle(); step(0,0,0,0,0,0); endtask

  initial begin
    #(CLK_P * 20000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    check("R1", "reset outputs", {tuneStart,tuneAbort,tuneReset,sampleSel,rdExec,rdSel}, 0);
    idle();
    // R2 start, R10 single pulse, no restart
    step(1,1,0,0,0,0);
    check("R2", "start pulse", tuneStart, 1);
    check("R2", "exec set", rdExec, 1);
    idle();
    check("R10", "start drops", tuneStart, 0);
    step(1,1,0,0,0,0);
    check("R2", "no restart", tuneStart, 0);
    // R3 pass
    step(0,0,0,0,1,1);
    check("R3", "exec cleared", rdExec, 0);
    check("R3", "sel pass", sampleSel, 1);
    check("R9", "rdSel follows", rdSel, 1);
    // R5 writing 1 ignored
    step(0,0,1,1,0,0);
    check("R5", "sel write 1", sampleSel, 1);
    check("R5", "no reset pulse", tuneReset, 0);
    // R7 start clears select
    step(1,1,0,0,0,0);
    check("R7", "start clears sel", sampleSel, 0);
    // R3 fail
    step(0,0,0,0,1,0);
    check("R3", "sel fail", sampleSel, 0);
    // pass then R6 clear
    step(1,1,0,0,0,0); step(0,0,0,0,1,1);
    check("R3", "sel pass again", sampleSel, 1);
    step(0,0,1,0,0,0);
    check("R6", "reset pulse", tuneReset, 1);
    check("R6", "sel cleared", sampleSel, 0);
    // R4 abort then late done
    step(1,1,0,0,0,0); idle();
    step(1,0,0,0,0,0);
    check("R4", "abort pulse", tuneAbort, 1);
    check("R4", "exec cleared", rdExec, 0);
    step(0,0,0,0,1,1);
    check("R4", "late done ignored", sampleSel, 0);
    // R4 abort and done in the same cycle
    step(1,1,0,0,0,0);
    step(1,0,0,0,1,1);
    check("R4", "abort wins", sampleSel, 0);
    check("R10", "abort single", tuneAbort, 1);
    idle();
    check("R10", "abort drops", tuneAbort, 0);
    // R8 busy holds a pass result
    rxBusy = 1;
    step(1,1,0,0,0,0); step(0,0,0,0,1,1); idle(); idle();
    check("R8", "held while busy", sampleSel, 0);
    rxBusy = 0;
    idle();
    check("R8", "applied after busy", sampleSel, 1);
    // R9 start while busy keeps sel at 1 but readback masked
    rxBusy = 1;
    step(1,1,0,0,0,0);
    check("R9", "sel frozen", sampleSel, 1);
    check("R9", "readback masked", rdSel, 0);
    step(0,0,0,0,1,1);
    // R8 newest pending wins: clear after the pass result
    step(0,0,1,0,0,0); idle();
    check("R8", "still held", sampleSel, 1);
    rxBusy = 0;
    idle();
    check("R8", "newest wins", sampleSel, 0);
    repeat (3) idle();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule